// File: doc/BRIEF.md
# Rotating Event-Queue Sieve Station

This block is one station of a wide sieving pipeline, built for progressions whose interval is large compared with the pipeline width. It keeps a circular store of pending events. Each event is a pair: a prime interval `p` and the index `a` at which that progression next contributes. The pipeline tells the station which block of `LANES` consecutive indices is passing it now. The station uses the block number to pick one slot of the store, the read head, so the head sweeps round the store as the pipeline advances.

In each cycle the station takes at most one eligible event from the head slot. It sends a contribution of floor(log2 p) to lane `a mod LANES`. It then moves the event to `a + p` and files it in the slot where that future block will be read, which is one lap or less behind the head. Each slot holds `WAYS` events. An event that finds its slot full moves to a later slot and is emitted up to `PROBE-1` blocks late. If every slot in that reach is full, the event is lost and a sticky error flag rises. The load port fills the store before sieving starts.

Top module: `prime_station`

## Requirements
- R1: During and directly after synchronous active-high reset, `out_valid` and `err` are 0 and the store is empty. No contribution appears until events are loaded.
- R2: A cycle with `load_valid=1` files the event (`load_p`, `load_a`) and emits nothing: `out_valid` is 0 in the following cycle. Filing uses the rules of R7.
- R3: An event is eligible when it sits in head slot `cur_blk mod DEPTH` and `(cur_blk - a/LANES) mod 2^(IDX_W-log2 LANES)` is below `PROBE`. When it is emitted, the cycle after the decision shows `out_valid=1`, `out_lane = a mod LANES` and `out_val = floor(log2 p)` (the bit position of the highest set bit of `p`).
- R4: An event in the head slot that is not eligible, such as one a lap ahead, is held. It is not emitted and stays stored for a later pass of the head.
- R5: An emitted event is filed again with index `(a + p) mod 2^IDX_W` and the same `p`. It is emitted again when its new block is at the station.
- R6: At most one event is emitted per cycle. When several events in the head slot are eligible, the lowest way goes first and the others follow in later cycles while they stay eligible.
- R7: Filing an event with index `a` tries slots `(a/LANES + k) mod DEPTH` for k = 0 up to `PROBE-1`, in that order. It takes the lowest free way of the first slot that has one.
- R8: When no way is free in any of those `PROBE` slots, the event is dropped and `err` goes to 1 in the next cycle. `err` then stays 1 until reset.
- R9: The way freed by an emission is free for that event's own refiling in the same cycle. An event with `p = LANES*DEPTH` goes back into the slot it came from.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_valid | input | 1 | Load an event this cycle (emission is skipped) |
| load_p | input | P_W | Interval of the loaded event |
| load_a | input | IDX_W | Next hit index of the loaded event |
| cur_blk | input | IDX_W-log2(LANES) | Number of the index block now at the station |
| out_valid | output | 1 | Contribution present |
| out_lane | output | log2(LANES) | Target lane, a mod LANES |
| out_val | output | log2(P_W) | Contribution value, floor(log2 p) |
| err | output | 1 | Sticky flag: an event found no free slot |

## Verification
Several properties are checked on every cycle. A load cycle never leads to an emission. The error flag never clears. Every emitted event lies inside the late window of the current block. Every filing lands on a way that is free after the emission's release. The event count never grows by more than one per cycle. The bench's scenarios are needed for the rest, which depends on the order of events in time: lowest-way priority within a slot, events held until a later lap, displaced events appearing one block late, and a refiled event coming back on every lap. A behavioural queue model predicts the outputs for those cases.

// File: rtl/station_pkg.sv
package station_pkg;
  // Bit position of the highest set bit, used as the log-value of an interval.
  function automatic int unsigned msb_pos(input logic [63:0] v, input int unsigned width);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 64; i++) begin
      if (i < int'(width) && v[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/station_log.sv
module station_log #(
  parameter int P_W = 16,
  localparam int LOG_W = $clog2(P_W)
) (
  input  logic [P_W-1:0]   p,
  output logic [LOG_W-1:0] lg
);
  always_comb begin
    lg = LOG_W'(station_pkg::msb_pos(64'(p), P_W));
  end
endmodule

// File: rtl/station_pick.sv
module station_pick #(
  parameter int WAYS  = 2,
  parameter int BLK_W = 14,
  parameter int PROBE = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]            vld,
  input  logic [WAYS-1:0][BLK_W-1:0] blk,
  input  logic [BLK_W-1:0]           cur_blk,
  output logic                       hit,
  output logic [WAY_W-1:0]           way
);
  always_comb begin
    hit = 1'b0;
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      logic [BLK_W-1:0] lag;
      lag = cur_blk - blk[w];
      if (vld[w] && lag < BLK_W'(PROBE)) begin
        hit = 1'b1;
        way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/station_probe.sv
module station_probe #(
  parameter int DEPTH = 64,
  parameter int WAYS  = 2,
  parameter int PROBE = 4,
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int ENT    = DEPTH * WAYS,
  localparam int ENT_W  = $clog2(ENT)
) (
  input  logic [ENT-1:0]    occ,
  input  logic [SLOT_W-1:0] start,
  output logic              found,
  output logic [ENT_W-1:0]  idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = PROBE - 1; k >= 0; k--) begin
      for (int w = WAYS - 1; w >= 0; w--) begin
        logic [SLOT_W-1:0] s;
        logic [ENT_W-1:0]  e;
        s = start + SLOT_W'(k);
        e = ENT_W'(s) * ENT_W'(WAYS) + ENT_W'(w);
        if (!occ[e]) begin
          found = 1'b1;
          idx   = e;
        end
      end
    end
  end
endmodule

// File: rtl/prime_station.sv
module prime_station #(
  parameter int IDX_W = 16,
  parameter int P_W   = 16,
  parameter int LANES = 4,
  parameter int DEPTH = 64,
  parameter int WAYS  = 2,
  parameter int PROBE = 4,
  localparam int LANE_W = $clog2(LANES),
  localparam int BLK_W  = IDX_W - LANE_W,
  localparam int LOG_W  = $clog2(P_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_valid,
  input  logic [P_W-1:0]    load_p,
  input  logic [IDX_W-1:0]  load_a,
  input  logic [BLK_W-1:0]  cur_blk,
  output logic              out_valid,
  output logic [LANE_W-1:0] out_lane,
  output logic [LOG_W-1:0]  out_val,
  output logic              err
);
  localparam int SLOT_W = $clog2(DEPTH);
  localparam int ENT    = DEPTH * WAYS;
  localparam int ENT_W  = $clog2(ENT);
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [ENT-1:0]   vld;
  logic [IDX_W-1:0] mem_a [ENT];
  logic [P_W-1:0]   mem_p [ENT];

  logic [SLOT_W-1:0]           head;
  logic [WAYS-1:0]             hv;
  logic [WAYS-1:0][BLK_W-1:0]  hblk;
  logic                        hit, proc;
  logic [WAY_W-1:0]            hway;
  logic [ENT_W-1:0]            sel_idx, fidx;
  logic [IDX_W-1:0]            sel_a, ins_a;
  logic [P_W-1:0]              sel_p, ins_p;
  logic                        ins_req, found;
  logic [ENT-1:0]              occ;
  logic [LOG_W-1:0]            lg;

  assign head = cur_blk[SLOT_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [ENT_W-1:0] e;
    assign e       = ENT_W'(head) * ENT_W'(WAYS) + ENT_W'(w);
    assign hv[w]   = vld[e];
    assign hblk[w] = mem_a[e][IDX_W-1:LANE_W];
  end

  station_pick #(.WAYS(WAYS), .BLK_W(BLK_W), .PROBE(PROBE)) u_pick (
    .vld(hv), .blk(hblk), .cur_blk(cur_blk), .hit(hit), .way(hway)
  );

  assign sel_idx = ENT_W'(head) * ENT_W'(WAYS) + ENT_W'(hway);
  assign sel_a   = mem_a[sel_idx];
  assign sel_p   = mem_p[sel_idx];
  assign proc    = hit && !load_valid;
  assign ins_req = load_valid || hit;
  assign ins_a   = load_valid ? load_a : sel_a + IDX_W'(sel_p);
  assign ins_p   = load_valid ? load_p : sel_p;

  always_comb begin
    occ = vld;
    if (proc) occ[sel_idx] = 1'b0;
  end

  station_probe #(.DEPTH(DEPTH), .WAYS(WAYS), .PROBE(PROBE)) u_probe (
    .occ(occ), .start(ins_a[LANE_W +: SLOT_W]), .found(found), .idx(fidx)
  );

  station_log #(.P_W(P_W)) u_log (.p(sel_p), .lg(lg));

  always_ff @(posedge clk) begin
    if (rst) begin
      vld       <= '0;
      out_valid <= 1'b0;
      out_lane  <= '0;
      out_val   <= '0;
      err       <= 1'b0;
    end else begin
      vld       <= occ | ((ins_req && found) ? (ENT'(1) << fidx) : '0);
      out_valid <= proc;
      out_lane  <= sel_a[LANE_W-1:0];
      out_val   <= lg;
      err       <= err | (ins_req && !found);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && ins_req && found) begin
      mem_a[fidx] <= ins_a;
      mem_p[fidx] <= ins_p;
    end
  end

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);
  p_load_no_emit_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$past(load_valid));
  p_window_r3: assert property (@(posedge clk) disable iff (rst)
    proc |-> (BLK_W'(cur_blk - sel_a[IDX_W-1:LANE_W]) < BLK_W'(PROBE)));
  p_one_per_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(vld) <= $past($countones(vld)) + 1);
  p_free_target_r9: assert property (@(posedge clk) disable iff (rst)
    (ins_req && found) |-> !occ[fidx]);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

// File: tb/prime_station_test.sv
`timescale 1ns/1ps
module prime_station_test;
  localparam int S = 4, D = 64, W = 2, PR = 4;
  localparam int BMASK = (1 << 14) - 1;

  logic clk = 0, rst = 1, load_valid = 0;
  logic [15:0] load_p = 0, load_a = 0;
  logic [13:0] cur_blk = 0;
  logic out_valid, err;
  logic [1:0] out_lane;
  logic [3:0] out_val;

  always #5 clk = ~clk;

  prime_station uut (.clk(clk), .rst(rst), .load_valid(load_valid), .load_p(load_p),
    .load_a(load_a), .cur_blk(cur_blk), .out_valid(out_valid), .out_lane(out_lane),
    .out_val(out_val), .err(err));

  bit mv [D][W];
  bit mr [D][W];
  int ma [D][W];
  int mp [D][W];
  bit m_v, m_err;
  int m_lane, m_val;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  function automatic int lg2(int v);
    int r = 0;
    for (int i = 0; i < 16; i++) if (v[i]) r = i;
    return r;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic step(string base);
    string tag = base;
    if (rst) begin
      for (int s = 0; s < D; s++) for (int w = 0; w < W; w++) mv[s][w] = 0;
      m_v = 0; m_err = 0; tag = "R1";
    end else begin
      int head = cur_blk % D;
      int hit = -1, hd = 0, nel = 0;
      bit held = 0, ins = 0, ir = 0;
      int ia = 0, ip = 0;
      for (int w = 0; w < W; w++) if (mv[head][w]) begin
        int d = (int'(cur_blk) - ma[head][w] / S) & BMASK;
        if (d < PR) begin nel++; if (hit < 0) begin hit = w; hd = d; end end
        else held = 1;
      end
      if (load_valid) begin
        ins = 1; ia = load_a; ip = load_p; m_v = 0; tag = "R2";
      end else if (hit >= 0) begin
        m_v = 1; m_lane = ma[head][hit] % S; m_val = lg2(mp[head][hit]);
        if (hd > 0) tag = "R7"; else if (nel > 1) tag = "R6";
        else if (mr[head][hit]) tag = "R5"; else tag = "R3";
        mv[head][hit] = 0; ins = 1; ir = 1;
        ia = (ma[head][hit] + mp[head][hit]) & 16'hFFFF; ip = mp[head][hit];
      end else begin
        m_v = 0; if (held) tag = "R4";
      end
      if (ins) begin
        bit placed = 0;
        for (int k = 0; k < PR; k++) begin
          int s = (ia / S + k) % D;
          for (int w = 0; w < W; w++) if (!placed && !mv[s][w]) begin
            placed = 1; mv[s][w] = 1; ma[s][w] = ia; mp[s][w] = ip; mr[s][w] = ir;
            if (ir && s == head) tag = "R9";
          end
        end
        if (!placed) begin m_err = 1; tag = "R8"; end
      end
    end
    @(posedge clk); #1;
    vectors++;
    if (out_valid !== m_v || err !== m_err ||
        (m_v && (out_lane !== 2'(m_lane) || out_val !== 4'(m_val)))) begin
      miscompares++;
      $display("FAIL %s: actual v=%b lane=%0d val=%0d err=%b expected v=%b lane=%0d val=%0d err=%b",
        tag, out_valid, out_lane, out_val, err, m_v, m_lane, m_val, m_err);
    end
  endtask

  task automatic load(int p, int a);
    load_valid = 1; load_p = 16'(p); load_a = 16'(a);
    step("R2");
    load_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    #1;
    rst = 1;
    repeat (3) step("R1");
    rst = 0;
    cur_blk = 14'd200;
    step("R1");
    load(300, 5);          // slot 1 way 0
    load(70, 6);           // slot 1 way 1: two eligible in block 1 (R6)
    load(256, 9);          // lap-length interval: refiled into its own slot (R9)
    load(150, 40);
    load(150, 40);
    load(150, 40);         // third spills to slot 11, emitted one block late (R7)
    load(600, 13 + 256);   // next-lap event held in slot 3 on the first lap (R4)
    for (int b = 0; b < 512; b++) begin
      cur_blk = 14'(b);
      step("R3");
      step("R5");
    end
    rst = 1;
    step("R1");
    rst = 0;
    cur_blk = 14'd100;
    for (int i = 0; i < 9; i++) load(300, 80);   // ninth finds no slot (R8)
    repeat (4) step("R8");
    finish_run();
  end
endmodule